// File: doc/BRIEF.md
# Product-Machine Equivalence Engine

This block decides whether two small Mealy machines, each with a one-bit input and a one-bit output, behave the same: whether every input sequence applied from their start states yields the same output sequence from both. Software or a neighbouring controller first fills each machine's transition table through a write port. Each entry gives the next state and the output for one (state, input) combination. It then pulses `start` together with one start-state mask per machine.

The engine builds the product machine on the fly. It seeds a FIFO work queue with every allowed pair of start states. For each queued pair it steps both machines under input 0 and then input 1. If the two outputs differ, it reports the first differing output at once. If they agree, it queues the pair of next states when that pair has not been seen before. A visited bitmap indexed by the pair keeps every pair from being processed more than once. When the queue runs dry, the machines are declared equivalent. Each machine has up to 2^S1W and 2^S2W states, which is 8 and 8 by default.

Top module: `fsm_equiv_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `equivalent`, `mismatch_s1`, `mismatch_s2` and `mismatch_in` are all 0.
- R2: A cycle with `wr_en` high and `busy` low stores `{wr_next, wr_out}` as the entry for state `wr_state` under input `wr_in`. The entry goes to machine one when `wr_sel`=0 and to machine two when `wr_sel`=1. Every later check uses the stored entry.
- R3: Table writes in a cycle where `busy` is high are ignored, and a later check sees the tables unchanged.
- R4: A `start` pulse while `busy` is low clears the visited bitmap and the queue, latches both masks, drops `done`, and raises `busy` in the next cycle. A `start` while `busy` is high is ignored and does not change the result.
- R5: The initial pairs are every (a,b) with `start_mask1[a]` and `start_mask2[b]` set. They are queued in ascending order of a*2^S2W+b.
- R6: Pairs are processed in FIFO order. For each pair, input 0 is evaluated before input 1. The successor pair (next1,next2) is appended only if it was never queued before.
- R7: At the first evaluated (pair, input) whose two outputs differ, the engine stops. It raises `done` with `equivalent`=0, and `mismatch_s1`, `mismatch_s2` and `mismatch_in` hold that pair and input.
- R8: If the queue empties with no disagreement, `done` rises with `equivalent`=1 and all mismatch fields 0.
- R9: `done` and `busy` are never high together. Once `done` is high, it and all result outputs stay unchanged until the next accepted `start`.
- R10: With no pair selected by the masks, the check ends with `equivalent`=1.
- R11: The queue never holds more than 2^S1W*2^S2W pairs, even when every product pair is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Table select: 0 for machine one, 1 for machine two |
| wr_state | input | WW | State whose entry is written |
| wr_in | input | 1 | Input value of the written entry |
| wr_next | input | WW | Next state stored in the entry |
| wr_out | input | 1 | Output stored in the entry |
| start | input | 1 | Begin a check |
| start_mask1 | input | 2^S1W | Allowed start states of machine one |
| start_mask2 | input | 2^S2W | Allowed start states of machine two |
| busy | output | 1 | Check in progress |
| done | output | 1 | Result valid |
| equivalent | output | 1 | Machines found equivalent |
| mismatch_s1 | output | S1W | Machine-one state of the failing pair |
| mismatch_s2 | output | S2W | Machine-two state of the failing pair |
| mismatch_in | output | 1 | Input value that exposed the mismatch |

## Verification
In the input-1 step of an agreeing pair, the queue receives a newly found successor and releases the pair just finished, both in the same cycle. The sharpest case is a pair of ring machines whose product reaches all 64 pairs, so this simultaneous push and pop happens on nearly every pair. A chain of independently generated and relabelled machine pairs exercises it further. Each outcome (equivalence, or the exact failing pair and input) is compared with a breadth-first model in the bench that follows the seeding and FIFO order stated in the requirements. The queue bound is watched by an assertion.

// File: rtl/fsm_equiv_pkg.sv
package fsm_equiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_POP,
    ST_EXP,
    ST_DONE
  } eng_state_t;
endpackage

// File: rtl/fsm_table.sv
module fsm_table #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wa_state,
  input  logic          wa_in,
  input  logic [SW-1:0] wd_next,
  input  logic          wd_out,
  input  logic [SW-1:0] ra_state,
  input  logic          ra_in,
  output logic [SW-1:0] rd_next,
  output logic          rd_out
);
  localparam int ENTRIES = 1 << (SW + 1);

  logic [SW:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[{wa_state, wa_in}] <= {wd_next, wd_out};
  end

  assign rd_next = mem[{ra_state, ra_in}][SW:1];
  assign rd_out  = mem[{ra_state, ra_in}][0];
endmodule

// File: rtl/pair_queue.sv
module pair_queue #(
  parameter int W     = 6,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/visited_map.sv
module visited_map #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         set,
  input  logic [W-1:0] idx,
  output logic         hit
);
  localparam int N = 1 << W;

  logic [N-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst || clr)  bits      <= '0;
    else if (set)    bits[idx] <= 1'b1;
  end

  assign hit = bits[idx];
endmodule

// File: rtl/fsm_equiv_engine.sv
module fsm_equiv_engine #(
  parameter int S1W = 3,
  parameter int S2W = 3,
  parameter int WW  = (S1W > S2W) ? S1W : S2W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WW-1:0]     wr_state,
  input  logic              wr_in,
  input  logic [WW-1:0]     wr_next,
  input  logic              wr_out,
  input  logic              start,
  input  logic [(1<<S1W)-1:0] start_mask1,
  input  logic [(1<<S2W)-1:0] start_mask2,
  output logic              busy,
  output logic              done,
  output logic              equivalent,
  output logic [S1W-1:0]    mismatch_s1,
  output logic [S2W-1:0]    mismatch_s2,
  output logic              mismatch_in
);
  import fsm_equiv_pkg::*;

  localparam int N1    = 1 << S1W;
  localparam int N2    = 1 << S2W;
  localparam int PW    = S1W + S2W;
  localparam int DEPTH = N1 * N2;
  localparam int CW    = $clog2(DEPTH + 1);

  eng_state_t       st;
  logic             busy_q, done_q, eq_q;
  logic [S1W-1:0]   ms1_q;
  logic [S2W-1:0]   ms2_q;
  logic             min_q;
  logic [N1-1:0]    m1_q;
  logic [N2-1:0]    m2_q;
  logic [PW-1:0]    seed_idx;
  logic             cur_in;

  logic             start_ok;
  logic [PW-1:0]    head;
  logic             q_empty;
  logic [CW-1:0]    q_count;
  logic             q_push, q_pop;
  logic [PW-1:0]    q_data;
  logic             vis_hit;
  logic [S1W-1:0]   s1, n1, seed_s1;
  logic [S2W-1:0]   s2, n2, seed_s2;
  logic             o1, o2;
  logic             in_seed, in_exp, outs_differ, seed_hit;

  assign start_ok = start && !busy_q;
  assign s1       = head[PW-1:S2W];
  assign s2       = head[S2W-1:0];
  assign seed_s1  = seed_idx[PW-1:S2W];
  assign seed_s2  = seed_idx[S2W-1:0];
  assign in_seed  = (st == ST_SEED);
  assign in_exp   = (st == ST_EXP);
  assign seed_hit = m1_q[seed_s1] && m2_q[seed_s2];
  assign outs_differ = (o1 != o2);
  assign q_data   = in_seed ? seed_idx : {n1, n2};
  assign q_push   = (in_seed && seed_hit) || (in_exp && !outs_differ && !vis_hit);
  assign q_pop    = in_exp && !outs_differ && cur_in;

  fsm_table #(.SW(S1W)) u_tab1 (
    .clk(clk), .we(wr_en && !busy_q && !wr_sel),
    .wa_state(wr_state[S1W-1:0]), .wa_in(wr_in),
    .wd_next(wr_next[S1W-1:0]), .wd_out(wr_out),
    .ra_state(s1), .ra_in(cur_in), .rd_next(n1), .rd_out(o1)
  );

  fsm_table #(.SW(S2W)) u_tab2 (
    .clk(clk), .we(wr_en && !busy_q && wr_sel),
    .wa_state(wr_state[S2W-1:0]), .wa_in(wr_in),
    .wd_next(wr_next[S2W-1:0]), .wd_out(wr_out),
    .ra_state(s2), .ra_in(cur_in), .rd_next(n2), .rd_out(o2)
  );

  pair_queue #(.W(PW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .clr(start_ok),
    .push(q_push), .push_data(q_data), .pop(q_pop),
    .head(head), .empty(q_empty), .count(q_count)
  );

  visited_map #(.W(PW)) u_seen (
    .clk(clk), .rst(rst), .clr(start_ok),
    .set(q_push), .idx(q_data), .hit(vis_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      eq_q     <= 1'b0;
      ms1_q    <= '0;
      ms2_q    <= '0;
      min_q    <= 1'b0;
      m1_q     <= '0;
      m2_q     <= '0;
      seed_idx <= '0;
      cur_in   <= 1'b0;
    end else if (start_ok) begin
      st       <= ST_SEED;
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      eq_q     <= 1'b0;
      ms1_q    <= '0;
      ms2_q    <= '0;
      min_q    <= 1'b0;
      m1_q     <= start_mask1;
      m2_q     <= start_mask2;
      seed_idx <= '0;
      cur_in   <= 1'b0;
    end else begin
      case (st)
        ST_SEED: begin
          seed_idx <= seed_idx + 1'b1;
          if (seed_idx == PW'(DEPTH - 1)) st <= ST_POP;
        end
        ST_POP: begin
          if (q_empty) begin
            st     <= ST_DONE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            eq_q   <= 1'b1;
          end else begin
            st     <= ST_EXP;
            cur_in <= 1'b0;
          end
        end
        ST_EXP: begin
          if (outs_differ) begin
            st     <= ST_DONE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            eq_q   <= 1'b0;
            ms1_q  <= s1;
            ms2_q  <= s2;
            min_q  <= cur_in;
          end else if (cur_in) begin
            st <= ST_POP;
          end else begin
            cur_in <= 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign equivalent  = eq_q;
  assign mismatch_s1 = ms1_q;
  assign mismatch_s2 = ms2_q;
  assign mismatch_in = min_q;
endmodule

// File: rtl/fsm_equiv_chk.sv
module fsm_equiv_chk #(
  parameter int S1W = 3,
  parameter int S2W = 3,
  parameter int CW  = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           equivalent,
  input logic [S1W-1:0] mismatch_s1,
  input logic [S2W-1:0] mismatch_s2,
  input logic           mismatch_in,
  input logic [CW-1:0]  q_count
);
  localparam int DEPTH = (1 << S1W) * (1 << S2W);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R4
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(equivalent) && $stable(mismatch_s1)
                          && $stable(mismatch_s2) && $stable(mismatch_in)));

  // R8
  equiv_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (done && equivalent) |-> (mismatch_s1 == '0 && mismatch_s2 == '0 && !mismatch_in));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));
endmodule

bind fsm_equiv_engine fsm_equiv_chk #(.S1W(S1W), .S2W(S2W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .equivalent(equivalent), .mismatch_s1(mismatch_s1), .mismatch_s2(mismatch_s2),
  .mismatch_in(mismatch_in), .q_count(q_count)
);

// File: tb/fsm_equiv_engine_tb.sv
module fsm_equiv_engine_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0, wr_in = 1'b0, wr_out = 1'b0;
  logic [2:0] wr_state = '0, wr_next = '0;
  logic       start = 1'b0;
  logic [7:0] start_mask1 = '0, start_mask2 = '0;
  logic       busy, done, equivalent, mismatch_in;
  logic [2:0] mismatch_s1, mismatch_s2;

  int t1n [N][2];
  int t1o [N][2];
  int t2n [N][2];
  int t2o [N][2];
  int n_chk = 0, n_fail = 0;
  int lcg = 12345;

  always #2 clk = ~clk;

  fsm_equiv_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_state(wr_state),
    .wr_in(wr_in), .wr_next(wr_next), .wr_out(wr_out), .start(start),
    .start_mask1(start_mask1), .start_mask2(start_mask2), .busy(busy),
    .done(done), .equivalent(equivalent), .mismatch_s1(mismatch_s1),
    .mismatch_s2(mismatch_s2), .mismatch_in(mismatch_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 16) & 32'h7fff;
  endfunction

  function automatic void model(input int m1, input int m2, output bit eq,
                                output int e1, output int e2, output int eb);
    bit vis [64];
    int q [64];
    int h = 0, t = 0;
    for (int i = 0; i < 64; i++) vis[i] = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (m1[a] && m2[b]) begin vis[a*8+b] = 1'b1; q[t] = a*8+b; t++; end
    eq = 1'b1; e1 = 0; e2 = 0; eb = 0;
    while (h < t) begin
      int a = q[h] / 8;
      int b = q[h] % 8;
      h++;
      for (int i = 0; i < 2; i++) begin
        int np;
        if (t1o[a][i] != t2o[b][i]) begin
          eq = 1'b0; e1 = a; e2 = b; eb = i;
          return;
        end
        np = t1n[a][i] * 8 + t2n[b][i];
        if (!vis[np]) begin vis[np] = 1'b1; q[t] = np; t++; end
      end
    end
  endfunction

  task automatic put(input bit sel, input int s, input int b, input int nx, input int o);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_state = s[2:0]; wr_in = b[0];
    wr_next = nx[2:0]; wr_out = o[0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int s = 0; s < N; s++)
      for (int b = 0; b < 2; b++) begin
        put(1'b0, s, b, t1n[s][b], t1o[s][b]);
        put(1'b1, s, b, t2n[s][b], t2o[s][b]);
      end
  endtask

  task automatic fire(input int m1, input int m2);
    @(negedge clk);
    start = 1'b1; start_mask1 = m1[7:0]; start_mask2 = m2[7:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(done, {req, " done"}, done, 1);
  endtask

  task automatic judge(input int m1, input int m2, input string req);
    bit eq; int e1, e2, eb;
    model(m1, m2, eq, e1, e2, eb);
    chk(equivalent == eq, {req, " equivalent"}, equivalent, eq);
    if (!eq) begin
      chk(mismatch_s1 == e1[2:0] && mismatch_s2 == e2[2:0] && mismatch_in == eb[0],
          {req, " mismatch pair"}, {mismatch_s1, mismatch_s2, mismatch_in},
          e1*16 + e2*2 + eb);
    end else begin
      chk(mismatch_s1 == 0 && mismatch_s2 == 0 && !mismatch_in,
          {req, " mismatch clear"}, {mismatch_s1, mismatch_s2, mismatch_in}, 0);
    end
  endtask

  task automatic run(input int m1, input int m2, input string req);
    fire(m1, m2);
    wait_done(req);
    judge(m1, m2, req);
  endtask

  task automatic set_selftest();
    for (int s = 0; s < N; s++) for (int b = 0; b < 2; b++) begin
      t1n[s][b] = s; t1o[s][b] = 0; t2n[s][b] = s; t2o[s][b] = 0;
    end
    // machine one: A=0 B=1 C=2 D=3
    t1n[0][0] = 1; t1o[0][0] = 0; t1n[0][1] = 0; t1o[0][1] = 1;
    t1n[1][0] = 3; t1o[1][0] = 1; t1n[1][1] = 2; t1o[1][1] = 0;
    t1n[2][0] = 1; t1o[2][0] = 1; t1n[2][1] = 0; t1o[2][1] = 1;
    t1n[3][0] = 3; t1o[3][0] = 1; t1n[3][1] = 2; t1o[3][1] = 0;
    // machine two: X=0 Y=1 Z=2
    t2n[0][0] = 0; t2o[0][0] = 1; t2n[0][1] = 2; t2o[0][1] = 0;
    t2n[1][0] = 0; t2o[1][0] = 0; t2n[1][1] = 1; t2o[1][1] = 1;
    t2n[2][0] = 0; t2o[2][0] = 1; t2n[2][1] = 1; t2o[2][1] = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !equivalent, "R1 flags", {busy, done, equivalent}, 0);
    chk(mismatch_s1 == 0 && mismatch_s2 == 0 && !mismatch_in, "R1 mismatch",
        {mismatch_s1, mismatch_s2, mismatch_in}, 0);

    // R5 R6 R8: self-test pair, A and Y as starts
    set_selftest();
    load_all();
    fire(1, 2);
    chk(busy && !done, "R4 busy after start", {busy, done}, 2);
    wait_done("R8 selftest");
    judge(1, 2, "R8 selftest");

    // R9 results hold
    repeat (5) @(negedge clk);
    chk(done && equivalent && !busy, "R9 hold", {busy, done, equivalent}, 3);

    // R5 two start states for machine one: (A,Y),(B,Y) -> fails at B,Y,0
    run(3, 2, "R5 two starts");
    chk(mismatch_s1 == 1 && mismatch_s2 == 1 && mismatch_in == 0, "R5 pair B,Y,0",
        {mismatch_s1, mismatch_s2, mismatch_in}, 18);

    // R10 empty seed
    run(0, 2, "R10 empty");
    chk(equivalent, "R10 equivalent", equivalent, 1);

    // R2 R7 single-entry output flips on reachable states
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 2; b++) begin
        t1o[a][b] ^= 1;
        put(1'b0, a, b, t1n[a][b], t1o[a][b]);
        run(1, 2, "R7 flip");
        chk(!equivalent, "R2 write took effect", equivalent, 0);
        t1o[a][b] ^= 1;
        put(1'b0, a, b, t1n[a][b], t1o[a][b]);
      end

    // R3 write while busy is ignored
    fire(1, 2);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_state = 3'd0; wr_in = 1'b1;
    wr_next = 3'd0; wr_out = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    wait_done("R3 busy write");
    judge(1, 2, "R3 busy write");
    run(1, 2, "R3 table unchanged");

    // R4 start while busy is ignored
    fire(1, 2);
    repeat (3) @(negedge clk);
    start = 1'b1; start_mask1 = 8'd3; start_mask2 = 8'd2;
    @(negedge clk);
    start = 1'b0;
    wait_done("R4 restart ignored");
    chk(equivalent, "R4 restart ignored", equivalent, 1);

    // R11 all 64 pairs reachable
    for (int s = 0; s < N; s++) begin
      t1n[s][0] = s; t1n[s][1] = (s + 1) % N; t1o[s][0] = 0; t1o[s][1] = 0;
      t2n[s][0] = (s + 1) % N; t2n[s][1] = s; t2o[s][0] = 0; t2o[s][1] = 0;
    end
    load_all();
    run(1, 1, "R11 full product");
    chk(equivalent, "R11 equivalent", equivalent, 1);

    // R6 R7 R8 sweep: relabelled copies and independent machines
    for (int r = 0; r < 24; r++) begin
      int m1 = (rnd() & 255) | 1;
      int m2 = 0;
      int k = rnd() & 7;
      for (int s = 0; s < N; s++) for (int b = 0; b < 2; b++) begin
        t1n[s][b] = rnd() & 7;
        t1o[s][b] = ((rnd() & 7) == 0) ? 1 : 0;
      end
      if (r % 2 == 0) begin
        for (int s = 0; s < N; s++) for (int b = 0; b < 2; b++) begin
          t2n[s ^ k][b] = t1n[s][b] ^ k;
          t2o[s ^ k][b] = t1o[s][b];
        end
        for (int s = 0; s < N; s++) if (m1[s]) m2 |= (1 << (s ^ k));
      end else begin
        for (int s = 0; s < N; s++) for (int b = 0; b < 2; b++) begin
          t2n[s][b] = rnd() & 7;
          t2o[s][b] = ((rnd() & 7) == 0) ? 1 : 0;
        end
        m2 = (rnd() & 255) | 1;
      end
      load_all();
      run(m1, m2, "R6 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule